// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins, arranged as two banks of eight. Software reaches it through a byte-wide register port with an address, write data, a write strobe, a read strobe and read data. Each pin has two configuration bytes. The output byte sets the pad controls: drive direction, open-drain or push-pull drive, pull resistor enable, pull selection and the driven value. The input byte reads back the synchronized pin level and selects which edges raise an interrupt.

Every pin passes through a two-flop synchronizer, and edges are found by comparing the synchronized level with its previous sample. A qualifying edge sets a sticky pending flag, whether or not the pin is masked. Software clears a flag by writing a one to its bit. Each bank has a primary mask, and the single interrupt line is the OR of all pending flags whose primary mask bit is clear. A second set of mask bytes, intended for a low-power state, can be read and written but does not gate the interrupt line.

The register port has no back-pressure. Every access is accepted in the cycle its strobe is high, and no handshake exists at this edge. Pad controls are plain level outputs.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, every output byte reads 0x0A: input direction, push-pull, pull enabled, strong pull-up. Every other register reads 0x00 and `irq` is low.
- R2: Output bytes sit at 0x2B+n (bank 0) and 0x3B+n (bank 1), where n is the pin index within the bank. In each byte, bit 5 drives `pin_oe`, bit 4 drives `pin_od`, bit 3 drives `pull_en`, bits 2:1 drive the pin's two-bit `pull_sel` field (00 weak-strong down, 01 strong up, 10 weak down, 11 weak up), and bit 0 drives `pin_out`. Bits 7:6 read as zero.
- R3: Input bytes sit at 0x33+n (bank 0) and 0x43+n (bank 1). Bit 0 reads the synchronized level: a change first sampled at clock edge k is returned by a read taken at edge k+2, and a read taken at edge k+1 still returns the old level. Bits 2:1 are writable. All other bits read zero.
- R4: Input-byte bits 2:1 choose the edge: 00 none, 01 falling, 10 rising, 11 both. A pin change first sampled at edge k sets that pin's pending bit at edge k+2. Pending bytes are at 0x0B (bank 0) and 0x0C (bank 1), and bit i is pin i of the bank. The bit is set even when the pin is masked.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R6: When an edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R7: `irq` is high exactly when some pending bit has its primary mask bit clear. Primary masks are at 0x19 (bank 0) and 0x1A (bank 1), and a 1 masks the pin.
- R8: Secondary masks at 0x1B and 0x1C read back what was written and have no effect on `irq`.
- R9: Unmapped addresses read as 0x00, and writes to them change nothing.
- R10: `rdata` shows the selected register one cycle after `rd_en` and is 0x00 in any cycle that follows no read. A read and a write to the same address in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Driven value per pin |
| pin_oe | output | 16 | Output enable per pin |
| pin_od | output | 16 | Open-drain select per pin |
| pull_en | output | 16 | Pull resistor enable per pin |
| pull_sel | output | 32 | Pull choice, two bits per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a clearing write landing in the same cycle that an edge reaches the pending register (R6). The detection delay is three register stages, so the bench toggles a pin and then asserts the clearing write exactly two clocks later, which puts both events on the same edge. The sampling latency on its own (R3) is checked by reading the level one clock too early and then again after the full delay. A behavioural model, built on a history queue of pin samples, is compared with every output on every clock. This catches any slip of a cycle in these timings.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int CTLO_W      = 6;
  localparam int BANK_STRIDE = 16;

  localparam logic [ADDR_W-1:0] PEND_BASE  = 8'h0B;
  localparam logic [ADDR_W-1:0] MASK_BASE  = 8'h19;
  localparam logic [ADDR_W-1:0] MASK2_BASE = 8'h1B;
  localparam logic [ADDR_W-1:0] CTLO_BASE  = 8'h2B;
  localparam logic [ADDR_W-1:0] CTLI_BASE  = 8'h33;

  localparam logic [CTLO_W-1:0] CTLO_RST = 6'h0A;

  // output-byte field positions
  localparam int OB_VAL  = 0;
  localparam int OB_PSEL = 1;
  localparam int OB_PEN  = 3;
  localparam int OB_OD   = 4;
  localparam int OB_DIR  = 5;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic [ADDR_W-1:0] ctlo_addr(input int pin, input int bank_w);
    return ADDR_W'(int'(CTLO_BASE) + (pin / bank_w) * BANK_STRIDE + (pin % bank_w));
  endfunction

  function automatic logic [ADDR_W-1:0] ctli_addr(input int pin, input int bank_w);
    return ADDR_W'(int'(CTLI_BASE) + (pin / bank_w) * BANK_STRIDE + (pin % bank_w));
  endfunction

  function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] base, input int bank);
    return ADDR_W'(int'(base) + bank);
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, stable_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
      prev_q   <= '0;
    end else begin
      meta_q   <= pin_i;
      stable_q <= meta_q;
      prev_q   <= stable_q;
    end
  end

  assign level_o = stable_q;
  assign rise_o  = stable_q & ~prev_q;
  assign fall_o  = ~stable_q & prev_q;
endmodule

// File: rtl/pinbank_cfg.sv
module pinbank_cfg
  import pinbank_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int BANK_W = 8,
  localparam int NPINS = BANKS * BANK_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [CTLO_W-1:0]             wdata,
  output logic [NPINS-1:0][CTLO_W-1:0]  ctlo_o,
  output logic [NPINS-1:0][1:0]         esel_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam logic [ADDR_W-1:0] A_OUT = ctlo_addr(p, BANK_W);
    localparam logic [ADDR_W-1:0] A_IN  = ctli_addr(p, BANK_W);
    logic [CTLO_W-1:0] ctlo_q;
    logic [1:0]        esel_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctlo_q <= CTLO_RST;
        esel_q <= EDGE_NONE;
      end else if (wr_en) begin
        if (addr == A_OUT) ctlo_q <= wdata;
        if (addr == A_IN)  esel_q <= wdata[2:1];
      end
    end

    assign ctlo_o[p] = ctlo_q;
    assign esel_o[p] = esel_q;
  end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int BANK_W = 8,
  localparam int NPINS = BANKS * BANK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NPINS-1:0]      rise_i,
  input  logic [NPINS-1:0]      fall_i,
  input  logic [NPINS-1:0][1:0] esel_i,
  output logic [NPINS-1:0]      pend_o,
  output logic [NPINS-1:0]      mask_o,
  output logic [NPINS-1:0]      mask2_o,
  output logic                  irq_o
);
  logic [NPINS-1:0] hit;

  always_comb begin
    hit = '0;
    for (int p = 0; p < NPINS; p++) begin
      case (edge_sel_e'(esel_i[p]))
        EDGE_FALL: hit[p] = fall_i[p];
        EDGE_RISE: hit[p] = rise_i[p];
        EDGE_BOTH: hit[p] = rise_i[p] | fall_i[p];
        default:   hit[p] = 1'b0;
      endcase
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_PEND  = bank_addr(PEND_BASE, b);
    localparam logic [ADDR_W-1:0] A_MASK  = bank_addr(MASK_BASE, b);
    localparam logic [ADDR_W-1:0] A_MASK2 = bank_addr(MASK2_BASE, b);
    logic [BANK_W-1:0] pend_q, mask_q, mask2_q, clr;

    assign clr = (wr_en && addr == A_PEND) ? wdata[BANK_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q  <= '0;
        mask_q  <= '0;
        mask2_q <= '0;
      end else begin
        // new edges win over a simultaneous clear
        pend_q <= (pend_q & ~clr) | hit[b*BANK_W +: BANK_W];
        if (wr_en && addr == A_MASK)  mask_q  <= wdata[BANK_W-1:0];
        if (wr_en && addr == A_MASK2) mask2_q <= wdata[BANK_W-1:0];
      end
    end

    assign pend_o[b*BANK_W +: BANK_W]  = pend_q;
    assign mask_o[b*BANK_W +: BANK_W]  = mask_q;
    assign mask2_o[b*BANK_W +: BANK_W] = mask2_q;
  end

  assign irq_o = |(pend_o & ~mask_o);
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int BANK_W = 8,
  localparam int NPINS = BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic [NPINS-1:0]     pin_od,
  output logic [NPINS-1:0]     pull_en,
  output logic [2*NPINS-1:0]   pull_sel,
  output logic                 irq
);
  logic [NPINS-1:0]             level_w, rise_w, fall_w;
  logic [NPINS-1:0][CTLO_W-1:0] ctlo_w;
  logic [NPINS-1:0][1:0]        esel_w;
  logic [NPINS-1:0]             pend_w, mask_w, mask2_w;
  logic [DATA_W-1:0]            rd_val, rdata_q;

  pinbank_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_in),
    .level_o (level_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  pinbank_cfg #(.BANKS(BANKS), .BANK_W(BANK_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata[CTLO_W-1:0]),
    .ctlo_o (ctlo_w),
    .esel_o (esel_w)
  );

  pinbank_irq #(.BANKS(BANKS), .BANK_W(BANK_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rise_i  (rise_w),
    .fall_i  (fall_w),
    .esel_i  (esel_w),
    .pend_o  (pend_w),
    .mask_o  (mask_w),
    .mask2_o (mask2_w),
    .irq_o   (irq)
  );

  // read decode: unmapped addresses fall through to zero
  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (addr == ctlo_addr(p, BANK_W)) rd_val = DATA_W'(ctlo_w[p]);
      if (addr == ctli_addr(p, BANK_W)) rd_val = DATA_W'({esel_w[p], level_w[p]});
    end
    for (int b = 0; b < BANKS; b++) begin
      if (addr == bank_addr(PEND_BASE, b))  rd_val = DATA_W'(pend_w[b*BANK_W +: BANK_W]);
      if (addr == bank_addr(MASK_BASE, b))  rd_val = DATA_W'(mask_w[b*BANK_W +: BANK_W]);
      if (addr == bank_addr(MASK2_BASE, b)) rd_val = DATA_W'(mask2_w[b*BANK_W +: BANK_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_en ? rd_val : '0;
  end
  assign rdata = rdata_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pin_out[p]         = ctlo_w[p][OB_VAL];
    assign pin_oe[p]          = ctlo_w[p][OB_DIR];
    assign pin_od[p]          = ctlo_w[p][OB_OD];
    assign pull_en[p]         = ctlo_w[p][OB_PEN];
    assign pull_sel[2*p +: 2] = ctlo_w[p][OB_PSEL +: 2];
  end
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
  import pinbank_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int BANK_W = 8,
  localparam int NPINS = BANKS * BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic [NPINS-1:0]  pend,
  input logic [NPINS-1:0]  mask,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq
);
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    logic m = 1'b0;
    for (int p = 0; p < NPINS; p++)
      if (a == ctlo_addr(p, BANK_W) || a == ctli_addr(p, BANK_W)) m = 1'b1;
    for (int b = 0; b < BANKS; b++)
      if (a == bank_addr(PEND_BASE, b) || a == bank_addr(MASK_BASE, b) ||
          a == bank_addr(MASK2_BASE, b)) m = 1'b1;
    return m;
  endfunction

  function automatic logic is_pend(input logic [ADDR_W-1:0] a);
    logic m = 1'b0;
    for (int b = 0; b < BANKS; b++)
      if (a == bank_addr(PEND_BASE, b)) m = 1'b1;
    return m;
  endfunction

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == '0);

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_mapped(addr)) |=> rdata == '0);

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_pend(addr)) |=> ((pend & $past(pend)) == $past(pend)));

  // R7
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe));
endmodule

bind pinbank_ctrl pinbank_chk #(.BANKS(BANKS), .BANK_W(BANK_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .addr   (addr),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .rdata  (rdata),
  .pend   (pend_w),
  .mask   (mask_w),
  .pin_oe (pin_oe),
  .irq    (irq)
);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] pins = '0;
  logic [7:0]  rdata;
  logic [15:0] pin_out, pin_oe, pin_od, pull_en;
  logic [31:0] pull_sel;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic started = 1'b0;

  always #10 clk = ~clk;

  pinbank_ctrl u_pinbank_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pins), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_od(pin_od), .pull_en(pull_en), .pull_sel(pull_sel),
    .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [5:0]  m_ctlo [16];
  logic [1:0]  m_esel [16];
  logic [15:0] m_pend, m_mask, m_mask2;
  logic [7:0]  m_rdata;
  logic [15:0] hist [$];
  logic [15:0] ev;
  logic [7:0]  rv;

  function automatic int out_pin(input logic [7:0] a);
    if (a >= 8'h2B && a <= 8'h32) return int'(a) - 'h2B;
    if (a >= 8'h3B && a <= 8'h42) return int'(a) - 'h3B + 8;
    return -1;
  endfunction

  function automatic int in_pin(input logic [7:0] a);
    if (a >= 8'h33 && a <= 8'h3A) return int'(a) - 'h33;
    if (a >= 8'h43 && a <= 8'h4A) return int'(a) - 'h43 + 8;
    return -1;
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] a);
    int op = out_pin(a);
    int ip = in_pin(a);
    if (op >= 0) return {2'b00, m_ctlo[op]};
    if (ip >= 0) return {5'b0, m_esel[ip], hist[1][ip]};
    case (a)
      8'h0B: return m_pend[7:0];
      8'h0C: return m_pend[15:8];
      8'h19: return m_mask[7:0];
      8'h1A: return m_mask[15:8];
      8'h1B: return m_mask2[7:0];
      8'h1C: return m_mask2[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 16; p++) begin m_ctlo[p] = 6'h0A; m_esel[p] = 2'b00; end
      m_pend = '0; m_mask = '0; m_mask2 = '0; m_rdata = '0;
      hist = '{16'h0, 16'h0, 16'h0};
    end else begin
      rv = rd_en ? mread(addr) : 8'h00;
      for (int p = 0; p < 16; p++) begin
        case (m_esel[p])
          2'b01: ev[p] = hist[0][p] & ~hist[1][p];
          2'b10: ev[p] = ~hist[0][p] & hist[1][p];
          2'b11: ev[p] = hist[0][p] ^ hist[1][p];
          default: ev[p] = 1'b0;
        endcase
      end
      if (wr_en && addr == 8'h0B) m_pend[7:0]  = m_pend[7:0]  & ~wdata;
      if (wr_en && addr == 8'h0C) m_pend[15:8] = m_pend[15:8] & ~wdata;
      m_pend = m_pend | ev;
      if (wr_en) begin
        if (out_pin(addr) >= 0) m_ctlo[out_pin(addr)] = wdata[5:0];
        if (in_pin(addr) >= 0)  m_esel[in_pin(addr)]  = wdata[2:1];
        case (addr)
          8'h19: m_mask[7:0]   = wdata;
          8'h1A: m_mask[15:8]  = wdata;
          8'h1B: m_mask2[7:0]  = wdata;
          8'h1C: m_mask2[15:8] = wdata;
          default: ;
        endcase
      end
      hist.push_back(pins);
      void'(hist.pop_front());
      m_rdata = rv;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && started) begin
      logic [15:0] e_out, e_oe, e_od, e_pe;
      logic [31:0] e_sel;
      for (int p = 0; p < 16; p++) begin
        e_out[p] = m_ctlo[p][0]; e_oe[p] = m_ctlo[p][5]; e_od[p] = m_ctlo[p][4];
        e_pe[p] = m_ctlo[p][3]; e_sel[2*p +: 2] = m_ctlo[p][2:1];
      end
      chk(rdata === m_rdata, "R10 rdata model", 32'(rdata), 32'(m_rdata));
      chk(irq === |(m_pend & ~m_mask), "R7 irq model", 32'(irq), 32'(|(m_pend & ~m_mask)));
      chk({pin_out, pin_oe} === {e_out, e_oe}, "R2 out/oe model", {pin_out, pin_oe}, {e_out, e_oe});
      chk({pin_od, pull_en} === {e_od, e_pe}, "R2 od/pull model", {pin_od, pull_en}, {e_od, e_pe});
      chk(pull_sel === e_sel, "R2 pull_sel model", pull_sel, e_sel);
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); d = rdata; rd_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(d === exp, req, 32'(d), 32'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
    chk(pull_en === 16'hFFFF && pin_oe === 16'h0, "R1 pad defaults", {pull_en, pin_oe}, 32'hFFFF0000);
    chk(pull_sel === 32'h55555555, "R1 pull_sel", pull_sel, 32'h55555555);
    rd_chk(8'h2B, 8'h0A, "R1 ctlo bank0");
    rd_chk(8'h42, 8'h0A, "R1 ctlo bank1");
    rd_chk(8'h33, 8'h00, "R1 ctli");
    rd_chk(8'h0B, 8'h00, "R1 pending");

    // R2 output byte fields
    wr(8'h2B, 8'h21);
    chk(pin_oe[0] === 1'b1 && pin_out[0] === 1'b1, "R2 dir/value", {pin_oe[0], pin_out[0]}, 3);
    rd_chk(8'h2B, 8'h21, "R2 readback");
    wr(8'h3D, 8'hFF);
    rd_chk(8'h3D, 8'h3F, "R2 bits 7:6 zero");
    chk(pin_od[10] === 1'b1 && pull_sel[21:20] === 2'b11, "R2 od/pull_sel", {pin_od[10], pull_sel[21:20]}, 7);

    // R3 synchronized level latency
    @(negedge clk); pins[3] = 1'b1;
    rd_chk(8'h36, 8'h00, "R3 level too early");
    rd_chk(8'h36, 8'h01, "R3 level after sync");
    wr(8'h36, 8'hFF);
    rd_chk(8'h36, 8'h07, "R3 edge bits");

    // R4 rising edge on pin 9
    wr(8'h44, 8'h04);
    @(negedge clk); pins[9] = 1'b1;
    idle(4);
    rd_chk(8'h0C, 8'h02, "R4 rising sets pending");
    chk(irq === 1'b1, "R7 irq on pending", 32'(irq), 1);

    // R5 write-one-to-clear
    wr(8'h0C, 8'h00);
    rd_chk(8'h0C, 8'h02, "R5 zero write keeps");
    wr(8'h0C, 8'h02);
    rd_chk(8'h0C, 8'h00, "R5 one write clears");
    chk(irq === 1'b0, "R7 irq after clear", 32'(irq), 0);

    // R4 falling ignored in rising mode, then falling mode
    @(negedge clk); pins[9] = 1'b0;
    idle(4);
    rd_chk(8'h0C, 8'h00, "R4 falling ignored");
    wr(8'h44, 8'h02);
    @(negedge clk); pins[9] = 1'b1;
    idle(4);
    rd_chk(8'h0C, 8'h00, "R4 rising ignored");
    @(negedge clk); pins[9] = 1'b0;
    idle(4);
    rd_chk(8'h0C, 8'h02, "R4 falling sets");

    // R7 primary mask
    wr(8'h1A, 8'h02);
    chk(irq === 1'b0, "R7 masked", 32'(irq), 0);
    rd_chk(8'h0C, 8'h02, "R4 pending despite mask");
    wr(8'h1A, 8'h00);
    chk(irq === 1'b1, "R7 unmasked", 32'(irq), 1);

    // R6 edge collides with clear (bit already set)
    wr(8'h44, 8'h06);
    @(negedge clk); pins[9] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 8'h0C; wdata = 8'h02; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd_chk(8'h0C, 8'h02, "R6 edge beats clear");
    wr(8'h0C, 8'h02);
    rd_chk(8'h0C, 8'h00, "R5 clear after collision");

    // R8 secondary masks
    wr(8'h1B, 8'hA5);
    wr(8'h1C, 8'hFF);
    rd_chk(8'h1B, 8'hA5, "R8 readback bank0");
    rd_chk(8'h1C, 8'hFF, "R8 readback bank1");
    @(negedge clk); pins[9] = 1'b0;
    idle(4);
    chk(irq === 1'b1, "R8 no effect on irq", 32'(irq), 1);

    // R9 unmapped addresses
    wr(8'h00, 8'hFF);
    wr(8'h4B, 8'hFF);
    rd_chk(8'h00, 8'h00, "R9 read 0x00");
    rd_chk(8'h4B, 8'h00, "R9 read 0x4B");
    rd_chk(8'h2A, 8'h00, "R9 read 0x2A");
    rd_chk(8'h19, 8'h00, "R9 no side effect");

    // R10 read during write returns old value
    wr(8'h19, 8'h11);
    @(negedge clk); addr = 8'h19; wdata = 8'h22; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk(rdata === 8'h11, "R10 old value", 32'(rdata), 32'h11);
    @(negedge clk);
    chk(rdata === 8'h00, "R10 idle zero", 32'(rdata), 0);
    rd_chk(8'h19, 8'h22, "R10 new value");

    idle(3);
    report();
  end
endmodule